// File: doc/BRIEF.md
# Next Instruction Address Generator

This unit sits in the fetch path of a processor core and decides, once per instruction, where the next fetch goes and whether the link register must be reloaded. It receives the address of the instruction in flight, its branch class, the immediate displacement fields, the absolute-address and link flags, the resolved branch decision, and the current link and count register contents. From these it forms either the sequential address, a relative or absolute immediate target, or a register-indirect target. Branch conditions are resolved elsewhere; the unit only consumes the taken decision.

When the link flag is set on any branch, the unit also produces a link-register write of the return address (the instruction address plus four). This write does not depend on whether the branch was taken. A register-indirect branch through the link register reads the value presented on the link input, so the jump uses the old link value and the write carries the new one. A narrow-address mode clears the upper half of every address the unit produces. All outputs are registered, so each result appears one clock after its inputs.

Top module: `nia_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, `nia`, `lr_wdata` and `lr_we` are all cleared to zero at that edge.
- R2: With `br_form` = 2'b00 (no branch), `nia` is `cia` + 4 (modulo 2^64) and `lr_we` is 0 even when `lk` is 1.
- R3: With `br_form` = 2'b01 (long immediate branch), the 24-bit `li_fld` with two zero bits appended below it is sign-extended to 64 bits. `nia` is that value when `aa` is 1, and `cia` plus that value when `aa` is 0. This branch is always taken, whatever `taken` is.
- R4: With `br_form` = 2'b10 (conditional immediate branch), the 14-bit `bd_fld` is extended the same way and combined with `cia` under `aa` as in R3 when `taken` is 1. When `taken` is 0, `nia` is `cia` + 4.
- R5: With `br_form` = 2'b11 (register-indirect branch) and `taken` = 1, `nia` is `lr_in` when `xl_use_ctr` is 0 and `ctr_in` when it is 1, with bits 1:0 forced to zero in either case. When `taken` is 0, `nia` is `cia` + 4.
- R6: For any `br_form` other than 2'b00 with `lk` = 1, `lr_we` is 1 and `lr_wdata` is `cia` + 4, whether or not the branch is taken. When `lk` = 0, `lr_we` is 0.
- R7: A register-indirect branch through the link register with `lk` = 1 targets the `lr_in` value of the same instruction while writing `cia` + 4 as link data.
- R8: When `mode32` is 1, bits 63:32 of `nia` and `lr_wdata` are zero and bits 31:0 wrap, so `cia` = 0xFFFFFFFC sequentially yields 0.
- R9: Each result appears on the outputs at the first rising edge after its inputs are presented, and the outputs hold their previous values until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cia | input | 64 | Address of the current instruction |
| br_form | input | 2 | Branch class: 00 none, 01 long immediate, 10 conditional immediate, 11 register-indirect |
| li_fld | input | 24 | Long immediate displacement field |
| bd_fld | input | 14 | Conditional immediate displacement field |
| aa | input | 1 | 1 = immediate is an absolute target, 0 = relative to `cia` |
| lk | input | 1 | 1 = reload the link register with the return address |
| taken | input | 1 | Resolved branch decision for conditional and register-indirect classes |
| xl_use_ctr | input | 1 | Register-indirect source: 0 link register, 1 count register |
| lr_in | input | 64 | Link register value before this instruction |
| ctr_in | input | 64 | Count register value |
| mode32 | input | 1 | 1 = narrow addressing, upper 32 bits of results cleared |
| nia | output | 64 | Next fetch address (registered) |
| lr_we | output | 1 | Link register write enable (registered) |
| lr_wdata | output | 64 | Link register write data (registered) |

## Verification
Every result of this unit is due exactly one rising edge after its inputs: the bench changes inputs on a falling edge, and it confirms that the outputs still show the previous instruction's results just after the change. It then reads the new target and link write on the next falling edge, half a period after the capturing edge. The sweep covers every branch class, flag, decision, register select and address mode, crossed with displacement extremes and addresses that wrap at 32 and 64 bits. The expected values are formed with signed integer arithmetic in the bench.

// File: rtl/nia_pkg.sv
// Package nia_pkg
// Shared encoding of the branch class seen by the next-address generator.
// Assumes the decoder presents the class as a 2-bit code with this mapping.
package nia_pkg;
    typedef enum logic [1:0] {
        BR_NONE     = 2'b00,
        BR_IMM_LONG = 2'b01,
        BR_IMM_COND = 2'b10,
        BR_REG      = 2'b11
    } br_form_e;
endpackage

// File: rtl/nia_imm_target.sv
// Module nia_imm_target
// Forms an immediate branch target: the displacement field is scaled by four
// (two zero bits appended), sign-extended to XLEN, and either used directly
// (absolute) or added to the branch's own address (relative).
// Assumes FW + 2 < XLEN. Pure combinational.
module nia_imm_target #(
    parameter int XLEN = 64,
    parameter int FW   = 24
) (
    input  logic [XLEN-1:0] cia,
    input  logic [FW-1:0]   fld,
    input  logic            aa,
    output logic [XLEN-1:0] tgt
);
    localparam int EXT_W = XLEN - FW - 2;

    logic [XLEN-1:0] disp;

    // Scale and sign-extend the displacement.
    always_comb begin
        disp = {{EXT_W{fld[FW-1]}}, fld, 2'b00};
    end

    // Choose absolute or address-relative target.
    always_comb begin
        tgt = aa ? disp : (cia + disp);
    end
endmodule

// File: rtl/nia_reg_target.sv
// Module nia_reg_target
// Forms a register-indirect target from the link or count register with the
// two lowest bits cleared so the result is word aligned.
// Assumes the register values are those in effect before the instruction.
module nia_reg_target #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] lr_val,
    input  logic [XLEN-1:0] ctr_val,
    input  logic            use_ctr,
    output logic [XLEN-1:0] tgt
);
    localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

    // Select source register and force word alignment.
    always_comb begin
        tgt = (use_ctr ? ctr_val : lr_val) & ALIGN_MASK;
    end
endmodule

// File: rtl/nia_trim.sv
// Module nia_trim
// Applies the address-mode width: in narrow mode the upper half of the
// address is cleared, otherwise the address passes unchanged.
// Assumes XLEN is even. Pure combinational.
module nia_trim #(
    parameter int XLEN = 64
) (
    input  logic            narrow,
    input  logic [XLEN-1:0] addr_in,
    output logic [XLEN-1:0] addr_out
);
    localparam int HALF = XLEN / 2;

    // Clear the upper half when narrow addressing is selected.
    always_comb begin
        addr_out = addr_in & {{HALF{~narrow}}, {HALF{1'b1}}};
    end
endmodule

// File: rtl/nia_gen.sv
// Module nia_gen
// Next instruction address generator. Each cycle it takes the current
// instruction's address and branch information, selects the next fetch
// address, and decides whether the link register is reloaded with the
// return address. All outputs are registered (one cycle latency).
// Assumes: branch conditions are resolved upstream (taken input); the long
// immediate class is unconditional; lr_in holds the pre-instruction value.
module nia_gen #(
    parameter int XLEN    = 64,
    parameter int LI_W    = 24,
    parameter int BD_W    = 14,
    parameter int STEP    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   cia,
    input  logic [1:0]        br_form,
    input  logic [LI_W-1:0]   li_fld,
    input  logic [BD_W-1:0]   bd_fld,
    input  logic              aa,
    input  logic              lk,
    input  logic              taken,
    input  logic              xl_use_ctr,
    input  logic [XLEN-1:0]   lr_in,
    input  logic [XLEN-1:0]   ctr_in,
    input  logic              mode32,
    output logic [XLEN-1:0]   nia,
    output logic              lr_we,
    output logic [XLEN-1:0]   lr_wdata
);
    import nia_pkg::*;

    localparam int N_IMM = 2;
    localparam int HALF  = XLEN / 2;

    br_form_e        form;
    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] imm_tgt [N_IMM];
    logic [XLEN-1:0] reg_tgt;
    logic [XLEN-1:0] raw_next;
    logic [XLEN-1:0] next_trim;
    logic [XLEN-1:0] link_trim;
    logic            link_wr;
    logic            primed_q;

    // Decode the branch class code.
    always_comb begin
        form = br_form_e'(br_form);
    end

    // Sequential successor and return address.
    always_comb begin
        seq_addr = cia + XLEN'(STEP);
    end

    // Immediate target builders: index 0 long field, index 1 conditional field.
    for (genvar g = 0; g < N_IMM; g++) begin : g_imm
        if (g == 0) begin : g_long
            nia_imm_target #(.XLEN(XLEN), .FW(LI_W)) u_imm (
                .cia (cia),
                .fld (li_fld),
                .aa  (aa),
                .tgt (imm_tgt[g])
            );
        end else begin : g_cond
            nia_imm_target #(.XLEN(XLEN), .FW(BD_W)) u_imm (
                .cia (cia),
                .fld (bd_fld),
                .aa  (aa),
                .tgt (imm_tgt[g])
            );
        end
    end

    nia_reg_target #(.XLEN(XLEN)) u_reg (
        .lr_val  (lr_in),
        .ctr_val (ctr_in),
        .use_ctr (xl_use_ctr),
        .tgt     (reg_tgt)
    );

    // Pick the next address by branch class and decision.
    always_comb begin
        unique case (form)
            BR_IMM_LONG: raw_next = imm_tgt[0];
            BR_IMM_COND: raw_next = taken ? imm_tgt[1] : seq_addr;
            BR_REG:      raw_next = taken ? reg_tgt    : seq_addr;
            default:     raw_next = seq_addr;
        endcase
    end

    // Link write applies to every branch class when the link flag is set.
    always_comb begin
        link_wr = lk && (form != BR_NONE);
    end

    nia_trim #(.XLEN(XLEN)) u_trim_next (
        .narrow   (mode32),
        .addr_in  (raw_next),
        .addr_out (next_trim)
    );

    nia_trim #(.XLEN(XLEN)) u_trim_link (
        .narrow   (mode32),
        .addr_in  (seq_addr),
        .addr_out (link_trim)
    );

    // Output registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nia      <= '0;
            lr_we    <= 1'b0;
            lr_wdata <= '0;
        end else begin
            nia      <= next_trim;
            lr_we    <= link_wr;
            lr_wdata <= link_trim;
        end
    end

    // Marks cycles whose outputs were loaded from inputs (for assertions).
    always_ff @(posedge clk) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (nia == '0 && !lr_we && lr_wdata == '0));

    p_no_link_plain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(br_form) == 2'b00) |-> !lr_we);

    p_reg_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(br_form) == 2'b11 && $past(taken)) |-> (nia[1:0] == 2'b00));

    p_link_on_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(br_form) != 2'b00) |-> (lr_we == $past(lk)));

    p_narrow_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(mode32)) |-> (nia[XLEN-1:HALF] == '0 && lr_wdata[XLEN-1:HALF] == '0));

    p_untaken_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(br_form) == 2'b10 && !$past(taken) && !$past(mode32))
            |-> (nia == $past(cia) + XLEN'(STEP)));
endmodule

// File: tb/nia_gen_tb.sv
module nia_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cia = '0;
    logic [1:0]  br_form = '0;
    logic [23:0] li_fld = '0;
    logic [13:0] bd_fld = '0;
    logic        aa = 1'b0, lk = 1'b0, taken = 1'b0, xl_use_ctr = 1'b0, mode32 = 1'b0;
    logic [63:0] lr_in = '0, ctr_in = '0;
    logic [63:0] nia, lr_wdata;
    logic        lr_we;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    nia_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cia(cia), .br_form(br_form), .li_fld(li_fld),
        .bd_fld(bd_fld), .aa(aa), .lk(lk), .taken(taken), .xl_use_ctr(xl_use_ctr),
        .lr_in(lr_in), .ctr_in(ctr_in), .mode32(mode32),
        .nia(nia), .lr_we(lr_we), .lr_wdata(lr_wdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] narrow(input logic [63:0] a, input bit m);
        return m ? {32'h0, a[31:0]} : a;
    endfunction

    // Scaled signed displacement computed arithmetically.
    function automatic logic [63:0] disp(input longint raw, input int width);
        longint v;
        v = raw;
        if (v >= (longint'(1) << (width - 1))) v = v - (longint'(1) << width);
        return 64'(v * 4);
    endfunction

    logic [63:0] prev_nia, prev_wd;
    logic        prev_we;

    initial begin
        logic [23:0] li_tab [6];
        logic [13:0] bd_tab [6];
        logic [63:0] cia_tab [3];
        li_tab  = '{24'h000000, 24'h000001, 24'h7FFFFF, 24'h800000, 24'hFFFFFF, 24'h123456};
        bd_tab  = '{14'h0000, 14'h0001, 14'h1FFF, 14'h2000, 14'h3FFF, 14'h0ABC};
        cia_tab = '{64'h0000_0000_0000_1000, 64'h0000_0000_FFFF_FFFC, 64'hFFFF_FFFF_FFFF_FFFC};

        // R1: outputs cleared by reset, even with busy inputs.
        br_form = 2'b11; lk = 1'b1; taken = 1'b1; cia = 64'h55; lr_in = 64'hABCD;
        repeat (3) @(negedge clk);
        chk("R1 nia", nia, 64'h0);
        chk("R1 lr_we", {63'h0, lr_we}, 64'h0);
        chk("R1 lr_wdata", lr_wdata, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        prev_nia = nia; prev_we = lr_we; prev_wd = lr_wdata;

        for (int ci = 0; ci < 3; ci++) begin
            for (int ii = 0; ii < 6; ii++) begin
                for (int combo = 0; combo < 128; combo++) begin
                    logic [1:0]  f;
                    bit          a_, l_, t_, u_, m_;
                    logic [63:0] seq, e_nia, e_wd, lrv, ctv, src;
                    logic        e_we;
                    string       tag;
                    f  = combo[1:0];
                    a_ = combo[2]; l_ = combo[3]; t_ = combo[4]; u_ = combo[5]; m_ = combo[6];
                    lrv = 64'h0000_1234_5678_9ABF ^ (64'(ci) << 40);
                    ctv = 64'hFFFF_0000_8000_0003 ^ (64'(ii) << 8);

                    // Drive on the falling edge.
                    cia = cia_tab[ci]; br_form = f; li_fld = li_tab[ii]; bd_fld = bd_tab[ii];
                    aa = a_; lk = l_; taken = t_; xl_use_ctr = u_; mode32 = m_;
                    lr_in = lrv; ctr_in = ctv;

                    // Expected results.
                    seq = cia_tab[ci] + 64'd4;
                    case (f)
                        2'b00: begin e_nia = seq; tag = "R2"; end
                        2'b01: begin
                            e_nia = disp(longint'(li_tab[ii]), 24) + (a_ ? 64'h0 : cia_tab[ci]);
                            tag = "R3";
                        end
                        2'b10: begin
                            e_nia = t_ ? disp(longint'(bd_tab[ii]), 14) + (a_ ? 64'h0 : cia_tab[ci]) : seq;
                            tag = "R4";
                        end
                        default: begin
                            src = u_ ? ctv : lrv;
                            e_nia = t_ ? (src / 4) * 4 : seq;
                            tag = (l_ && !u_) ? "R7" : "R5";
                        end
                    endcase
                    e_nia = narrow(e_nia, m_);
                    e_we  = l_ && (f != 2'b00);
                    e_wd  = narrow(seq, m_);
                    if (m_) tag = {tag, "/R8"};

                    // R9: outputs unchanged before the capturing edge.
                    #1;
                    if (combo % 16 == 0) begin
                        chk("R9 hold nia", nia, prev_nia);
                        chk("R9 hold lr_we", {63'h0, lr_we}, {63'h0, prev_we});
                    end

                    @(negedge clk);
                    chk({tag, " nia"}, nia, e_nia);
                    chk({(f == 2'b00) ? "R2" : "R6", " lr_we"}, {63'h0, lr_we}, {63'h0, e_we});
                    chk({"R6 lr_wdata", m_ ? " R8" : ""}, lr_wdata, e_wd);
                    prev_nia = nia; prev_we = lr_we; prev_wd = lr_wdata;
                end
            end
        end

        // R8: explicit 32-bit wrap of the sequential address.
        cia = 64'h0000_0000_FFFF_FFFC; br_form = 2'b00; mode32 = 1'b1; lk = 1'b0;
        @(negedge clk);
        chk("R8 wrap", nia, 64'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule